// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory. On any rising clock edge where either of two independent start strobes is high, the full external address is captured and becomes the current address on the following cycle. From then on, the low two bits are stepped by an internal two-bit counter each time the advance input is high. The upper address bits stay fixed for the whole burst. Bursts are four words long and wrap inside their aligned four-word block.

An order-select input chooses between two sequences. Linear order adds the counter to the starting low bits. Interleaved order XORs the counter with them. The select is sampled together with the start address and held for that burst. A low select gives interleaved order, so an idle or undriven-low pin defaults to it. Bursting is optional: the host may assert a strobe on every cycle and load a fresh address each clock with no idle cycles. There is no data stream in this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `bsq_burst_seq`

## Requirements
- R1: While reset is low, and on the first cycle after its release, `addr_o` is 0 and `burst_pos_o` is 0.
- R2: A rising edge with `start_a_i` high makes `addr_o` equal that edge's `addr_i` and `burst_pos_o` equal 0 on the next cycle.
- R3: A rising edge with `start_b_i` high has the same effect as R2, and so does an edge with both strobes high.
- R4: An edge with no strobe and `advance_i` high increments `burst_pos_o` by one, modulo 4.
- R5: When `order_lin_i` was 1 at the loading edge, `addr_o[1:0]` equals (start low bits + `burst_pos_o`) mod 4.
- R6: When `order_lin_i` was 0 at the loading edge (interleaved order), `addr_o[1:0]` equals start low bits XOR `burst_pos_o`.
- R7: `addr_o[AW-1:2]` never changes except at a strobe edge. After four advances the address returns to the burst's start address.
- R8: When a strobe and `advance_i` are both high on the same edge, the strobe wins: the new address loads and `burst_pos_o` becomes 0.
- R9: An edge with no strobe and no advance leaves `addr_o` and `burst_pos_o` unchanged.
- R10: Strobes on consecutive edges each load their own address, one new address per cycle.
- R11: Changing `order_lin_i` during a burst, without a strobe, has no effect on that burst's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | External start address |
| start_a_i | input | 1 | First burst-start strobe |
| start_b_i | input | 1 | Second burst-start strobe |
| advance_i | input | 1 | Step to the next burst word |
| order_lin_i | input | 1 | 1 selects linear order, 0 selects interleaved |
| addr_o | output | AW | Current word address |
| burst_pos_o | output | 2 | Count of advances since the burst started, 0 to 3 |

## Verification
The checker tests on every cycle that a strobe edge loads the sampled address with position zero, even when advance is also high. It also tests that a plain advance steps the position by one, that an idle edge holds both outputs, and that the upper bits hold between strobes. The actual low-bit sequences depend on the order chosen at load time, so they are shown only by the bench's scenarios: linear and interleaved walks from every start offset, wrap after four words, a mid-burst change of the order pin, and back-to-back loads from alternating strobes.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } bsq_order_e;

  localparam int unsigned BSQ_CW = 2;

  typedef logic [BSQ_CW-1:0] bsq_cnt_t;

endpackage

// File: rtl/bsq_capture.sv
module bsq_capture
  import bsq_pkg::*;
#(
  parameter int unsigned AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          lin_in,
  output logic [AW-1:0] base_q,
  output bsq_order_e    order_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load) begin
      base_q  <= addr_in;
      order_q <= lin_in ? ORD_LINEAR : ORD_INTERLEAVE;
    end
  end

endmodule

// File: rtl/bsq_counter.sv
module bsq_counter
  import bsq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     step,
  output bsq_cnt_t cnt_q
);

  bsq_cnt_t cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + bsq_cnt_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bsq_order.sv
module bsq_order
  import bsq_pkg::*;
(
  input  bsq_cnt_t   start_low,
  input  bsq_cnt_t   cnt,
  input  bsq_order_e order,
  output bsq_cnt_t   word_low
);

  bsq_cnt_t lin_low;
  bsq_cnt_t ilv_low;

  always_comb begin
    lin_low  = start_low + cnt;
    ilv_low  = start_low ^ cnt;
    word_low = (order == ORD_LINEAR) ? lin_low : ilv_low;
  end

endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
#(
  parameter int unsigned AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          start_a_i,
  input  logic          start_b_i,
  input  logic          advance_i,
  input  logic          order_lin_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    burst_pos_o
);

  localparam int unsigned UW = AW - BSQ_CW;

  logic       load;
  logic       step;
  logic [AW-1:0] base_q;
  bsq_order_e order_q;
  bsq_cnt_t   cnt_q;
  bsq_cnt_t   word_low;

  // Either strobe starts a burst; a strobe overrides advance.
  assign load = start_a_i | start_b_i;
  assign step = advance_i & ~load;

  bsq_capture #(.AW(AW)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .addr_in (addr_i),
    .lin_in  (order_lin_i),
    .base_q  (base_q),
    .order_q (order_q)
  );

  bsq_counter u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .step  (step),
    .cnt_q (cnt_q)
  );

  bsq_order u_order (
    .start_low (base_q[BSQ_CW-1:0]),
    .cnt       (cnt_q),
    .order     (order_q),
    .word_low  (word_low)
  );

  generate
    if (UW > 0) begin : g_upper
      assign addr_o = {base_q[AW-1:BSQ_CW], word_low};
    end else begin : g_low_only
      assign addr_o = word_low;
    end
  endgenerate

  assign burst_pos_o = cnt_q;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_i,
  input logic          start_a_i,
  input logic          start_b_i,
  input logic          advance_i,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    burst_pos_o
);

  // R2 R3 R8: any strobe loads the address with position zero
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a_i || start_b_i) |=> (addr_o == $past(addr_i) && burst_pos_o == 2'd0));

  // R4: plain advance steps position
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a_i && !start_b_i && advance_i) |=> burst_pos_o == $past(burst_pos_o) + 2'd1);

  // R9: idle edge holds outputs
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a_i && !start_b_i && !advance_i) |=> ($stable(addr_o) && $stable(burst_pos_o)));

  // R7: upper bits fixed without a strobe
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a_i && !start_b_i) |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));

  // R8: advance with strobe does not step from old position
  p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_b_i && advance_i) |=> burst_pos_o == 2'd0);

endmodule

bind bsq_burst_seq bsq_checker #(.AW(AW)) u_bsq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_i      (addr_i),
  .start_a_i   (start_a_i),
  .start_b_i   (start_b_i),
  .advance_i   (advance_i),
  .addr_o      (addr_o),
  .burst_pos_o (burst_pos_o)
);

// File: tb/test_bsq_burst_seq.sv
module test_bsq_burst_seq;

  localparam int unsigned AW = 12;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    pos;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          start_a_i = 1'b0;
  logic          start_b_i = 1'b0;
  logic          advance_i = 1'b0;
  logic          order_lin_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    burst_pos_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  exp_t sb_q[$];

  // reference model state, derived from the requirements
  logic [AW-1:0] m_base = '0;
  logic          m_lin  = 1'b0;
  logic [1:0]    m_pos  = '0;

  always #4 clk = ~clk;

  bsq_burst_seq #(.AW(AW)) i_bsq_burst_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr_i),
    .start_a_i   (start_a_i),
    .start_b_i   (start_b_i),
    .advance_i   (advance_i),
    .order_lin_i (order_lin_i),
    .addr_o      (addr_o),
    .burst_pos_o (burst_pos_o)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = m_lin ? (m_base[1:0] + m_pos) : (m_base[1:0] ^ m_pos);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] a, input logic [1:0] p, input exp_t e);
    n_vec++;
    if (a !== e.addr || p !== e.pos) begin
      n_bad++;
      $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
               e.req, a, p, e.addr, e.pos);
    end
  endtask

  // driver: apply one cycle of stimulus, then push the expected result
  task automatic drive(input logic sa, input logic sb, input logic adv,
                       input logic lin, input logic [AW-1:0] a, input string req);
    exp_t e;
    @(negedge clk);
    start_a_i = sa; start_b_i = sb; advance_i = adv; order_lin_i = lin; addr_i = a;
    @(posedge clk);
    if (sa || sb) begin
      m_base = a; m_lin = lin; m_pos = 2'd0;
    end else if (adv) begin
      m_pos = m_pos + 2'd1;
    end
    e.addr = model_addr(); e.pos = m_pos; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) check(addr_o, burst_pos_o, sb_q.pop_front());
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.addr = '0; r.pos = '0; r.req = "R1 in reset";
    check(addr_o, burst_pos_o, r);
    rst_n = 1'b1;
    @(posedge clk); #2;
    r.req = "R1 after release";
    check(addr_o, burst_pos_o, r);

    // R2 + R5: linear walk from every start offset, with wrap (R7)
    for (int s = 0; s < 4; s++) begin
      drive(1, 0, 0, 1, 12'hA50 | 12'(s), "R2 load A linear");
      for (int k = 0; k < 4; k++) drive(0, 0, 1, 1, 12'hFFF, "R5 linear step");
    end
    // R3 + R6: interleaved walks, final advance wraps to start (R7)
    for (int s = 0; s < 4; s++) begin
      drive(0, 1, 0, 0, 12'h3C0 | 12'(s), "R3 load B interleave");
      for (int k = 0; k < 4; k++) drive(0, 0, 1, 0, 12'h000, "R6 interleave step R7 wrap");
    end
    // R3: both strobes
    drive(1, 1, 0, 1, 12'h7E2, "R3 both strobes");
    // R9: idle holds
    drive(0, 0, 1, 1, 12'h111, "R4 step");
    drive(0, 0, 0, 1, 12'h222, "R9 idle hold");
    drive(0, 0, 0, 0, 12'h333, "R9 idle hold");
    // R11: mode change mid-burst ignored
    drive(1, 0, 0, 0, 12'h5A3, "R2 load interleave");
    drive(0, 0, 1, 1, 12'h000, "R11 order pin ignored");
    drive(0, 0, 1, 1, 12'h000, "R11 order pin ignored");
    drive(0, 0, 1, 0, 12'h000, "R11 order pin ignored");
    // R8: strobe with advance
    drive(0, 1, 1, 1, 12'h9C6, "R8 strobe beats advance");
    drive(1, 0, 1, 0, 12'h0D1, "R8 strobe beats advance");
    drive(0, 0, 1, 0, 12'h0D1, "R4 step after load");
    // R10: load every cycle, alternating strobes
    for (int i = 0; i < 12; i++)
      drive(i[0], ~i[0], i[1], i[2], 12'(i * 12'h155 + 1), "R10 back-to-back load");
    drive(0, 0, 0, 0, 12'h000, "R9 idle hold");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule